// File: doc/BRIEF.md
# Min-Sum Check Node Processor (Degree 6)

This block is the check-side kernel of a min-sum LDPC decoder. On every cycle that its valid strobe is high, it takes six variable-to-check messages, one for each edge of a degree-6 check node. It then returns six check-to-variable messages, each extrinsic to its own edge. An outgoing sign is the parity of every incoming sign, folded once more with that edge's own sign. An outgoing magnitude is the smallest magnitude among the other five edges.

Sign and magnitude are handled by two independent sub-circuits. The magnitude side does one linear search that gives three values: the smallest magnitude, the edge that holds it and the second smallest magnitude. Each edge then picks the second minimum if it holds the minimum and the first minimum otherwise, so no edge needs its own five-input comparison. Results are registered and come out one cycle later with a valid flag. Normalisation, offsets, variable-node work, message storage and iteration control belong to the surrounding decoder.

Top module: `cnu_top`

## Requirements
- R1: Each message is 6 bits of sign-magnitude: edge e uses bits [6e+5:6e] of the packed bus, with bit 6e+5 as the sign (1 = negative) and bits [6e+4:6e] as the unsigned magnitude. The same layout holds for input and output.
- R2: When the outgoing magnitude on edge e is nonzero, its sign equals the incoming sign of edge e XOR the XOR of all six incoming signs.
- R3: The outgoing magnitude on edge e equals the minimum of the incoming magnitudes on the five edges other than e.
- R4: When the smallest magnitude appears on two or more edges, every edge outputs that value, including each edge that holds it.
- R5: An outgoing message whose magnitude is 0 carries sign bit 0.
- R6: The output is updated on the rising clock edge where valid_i is high. valid_o is high for exactly the cycle after each cycle in which valid_i is high, and low otherwise.
- R7: While valid_i is low, msg_o keeps its last value, whatever msg_i carries.
- R8: While rst_ni is low, valid_o is 0 and msg_o is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input messages valid this cycle |
| msg_i | input | 36 | Six packed variable-to-check messages |
| valid_o | output | 1 | Output messages valid |
| msg_o | output | 36 | Six packed check-to-variable messages |

## Verification
Every result sits one register stage after its input. msg_o and valid_o change on the rising edge where valid_i is high. The bench drives the inputs on a falling edge and removes valid_i on the next falling edge. It then samples on that same falling edge, half a cycle after the capturing rising edge. At that point it expects valid_o high and all six edges to match a brute-force exclusion-minimum reference. One falling edge later, with new data on msg_i and valid_i low, it expects valid_o low and msg_o unchanged.

// File: rtl/cnu_pkg.sv
package cnu_pkg;
  localparam int unsigned CNU_DEG   = 6;
  localparam int unsigned CNU_MAG_W = 5;
endpackage

// File: rtl/cnu_sign_unit.sv
module cnu_sign_unit #(
  parameter int unsigned DEG = cnu_pkg::CNU_DEG
) (
  input  logic [DEG-1:0] sign_i,
  output logic [DEG-1:0] sign_o,
  output logic           parity_o
);
  assign parity_o = ^sign_i;

  for (genvar e = 0; e < DEG; e++) begin : g_edge
    assign sign_o[e] = sign_i[e] ^ parity_o;
  end

  // r2: output parity is total parity for even degree, zero for odd
  always_comb begin
    if (!$isunknown(sign_i)) begin
      a_r2_sign_parity: assert ((^sign_o) == (((DEG % 2) == 0) ? (^sign_i) : 1'b0))
        else $error("sign parity mismatch");
    end
  end
endmodule

// File: rtl/cnu_mag_unit.sv
module cnu_mag_unit #(
  parameter int unsigned DEG   = cnu_pkg::CNU_DEG,
  parameter int unsigned MAG_W = cnu_pkg::CNU_MAG_W,
  localparam int unsigned IDX_W = (DEG > 1) ? $clog2(DEG) : 1
) (
  input  logic [DEG-1:0][MAG_W-1:0] mag_i,
  output logic [MAG_W-1:0]          min1_o,
  output logic [MAG_W-1:0]          min2_o,
  output logic [IDX_W-1:0]          idx_o
);
  always_comb begin
    min1_o = '1;
    min2_o = '1;
    idx_o  = '0;
    for (int i = 0; i < int'(DEG); i++) begin
      // strict compare keeps the lowest index; equal value drops to min2
      if (mag_i[i] < min1_o) begin
        min2_o = min1_o;
        min1_o = mag_i[i];
        idx_o  = IDX_W'(i);
      end else if (mag_i[i] < min2_o) begin
        min2_o = mag_i[i];
      end
    end
  end

  always_comb begin
    if (!$isunknown(mag_i)) begin
      a_r3_min_order: assert (min1_o <= min2_o) else $error("min1 above min2");
      a_r3_idx_holds_min: assert (mag_i[idx_o] == min1_o) else $error("idx not at min");
      for (int j = 0; j < int'(DEG); j++) begin
        a_r3_min1_bound: assert (mag_i[j] >= min1_o) else $error("min1 not minimal");
        if (IDX_W'(j) != idx_o) begin
          a_r4_min2_bound: assert (mag_i[j] >= min2_o) else $error("min2 not minimal");
        end
      end
    end
  end
endmodule

// File: rtl/cnu_edge_sel.sv
module cnu_edge_sel #(
  parameter int unsigned MAG_W = cnu_pkg::CNU_MAG_W,
  parameter int unsigned IDX_W = 3,
  parameter int unsigned EDGE  = 0
) (
  input  logic [MAG_W-1:0] min1_i,
  input  logic [MAG_W-1:0] min2_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             sign_i,
  output logic [MAG_W:0]   msg_o
);
  logic [MAG_W-1:0] mag;

  assign mag   = (idx_i == IDX_W'(EDGE)) ? min2_i : min1_i;
  assign msg_o = {sign_i & (mag != '0), mag};
endmodule

// File: rtl/cnu_top.sv
module cnu_top #(
  parameter int unsigned DEG   = cnu_pkg::CNU_DEG,
  parameter int unsigned MAG_W = cnu_pkg::CNU_MAG_W,
  localparam int unsigned MSG_W = MAG_W + 1,
  localparam int unsigned BUS_W = DEG * MSG_W,
  localparam int unsigned IDX_W = (DEG > 1) ? $clog2(DEG) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [BUS_W-1:0] msg_i,
  output logic             valid_o,
  output logic [BUS_W-1:0] msg_o
);
  logic [DEG-1:0]            sign_in;
  logic [DEG-1:0]            sign_ext;
  logic                      parity;
  logic [DEG-1:0][MAG_W-1:0] mag_in;
  logic [MAG_W-1:0]          min1, min2;
  logic [IDX_W-1:0]          min_idx;
  logic [BUS_W-1:0]          msg_d;

  for (genvar e = 0; e < DEG; e++) begin : g_unpack
    assign sign_in[e] = msg_i[e*MSG_W + MAG_W];
    assign mag_in[e]  = msg_i[e*MSG_W +: MAG_W];
  end

  cnu_sign_unit #(.DEG(DEG)) u_sign (
    .sign_i   (sign_in),
    .sign_o   (sign_ext),
    .parity_o (parity)
  );

  cnu_mag_unit #(.DEG(DEG), .MAG_W(MAG_W)) u_mag (
    .mag_i  (mag_in),
    .min1_o (min1),
    .min2_o (min2),
    .idx_o  (min_idx)
  );

  for (genvar e = 0; e < DEG; e++) begin : g_sel
    cnu_edge_sel #(.MAG_W(MAG_W), .IDX_W(IDX_W), .EDGE(e)) u_sel (
      .min1_i (min1),
      .min2_i (min2),
      .idx_i  (min_idx),
      .sign_i (sign_ext[e]),
      .msg_o  (msg_d[e*MSG_W +: MSG_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      msg_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) msg_o <= msg_d;
    end
  end

  a_r6_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o) else $error("valid_o missing");
  a_r6_valid_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o) else $error("valid_o spurious");
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(msg_o)) else $error("msg_o changed without valid");

  for (genvar e = 0; e < DEG; e++) begin : g_chk
    a_r5_zero_sign: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (msg_o[e*MSG_W +: MAG_W] == '0) |-> !msg_o[e*MSG_W + MAG_W])
      else $error("negative zero on edge %0d", e);
  end
endmodule

// File: tb/cnu_top_bench.sv
`timescale 1ns/1ps
module cnu_top_bench;
  localparam int DEG = 6;
  localparam int MW  = 5;
  localparam int SW  = 6;
  localparam int BW  = DEG * SW;
  localparam int NV  = 8;

  // m0..m5, sign mask (bit e = edge e)
  localparam int TAB [NV][7] = '{
    '{ 3,  9,  1, 20, 14,  7, 6'b000000},
    '{ 5,  5,  5,  5,  5,  5, 6'b101010},
    '{ 0,  4,  8, 12, 16, 31, 6'b111111},
    '{ 0,  6,  0,  2,  3,  4, 6'b010011},
    '{31, 31, 31, 31, 31, 31, 6'b000001},
    '{30, 29, 28, 27, 26,  1, 6'b100000},
    '{10,  2, 15,  2,  9, 11, 6'b001101},
    '{ 0,  0,  0,  0,  0,  0, 6'b111000}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [BW-1:0] msg_i = '0;
  logic          valid_o;
  logic [BW-1:0] msg_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  cnu_top u_cnu_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .msg_i(msg_i),
    .valid_o(valid_o), .msg_o(msg_o)
  );

  always #2 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [BW-1:0] ref_cnu(input logic [BW-1:0] m);
    logic [BW-1:0] r;
    logic par;
    r = '0;
    par = 1'b0;
    for (int e = 0; e < DEG; e++) par ^= m[e*SW + MW];
    for (int e = 0; e < DEG; e++) begin
      logic [MW-1:0] mn;
      logic s;
      mn = '1;
      for (int j = 0; j < DEG; j++)
        if (j != e && m[j*SW +: MW] < mn) mn = m[j*SW +: MW];
      s = m[e*SW + MW] ^ par;
      if (mn == 0) s = 1'b0;
      r[e*SW +: SW] = {s, mn};
    end
    return r;
  endfunction

  function automatic logic [BW-1:0] pack(input int row [7]);
    logic [BW-1:0] r;
    for (int e = 0; e < DEG; e++) begin
      r[e*SW +: MW]  = MW'(row[e]);
      r[e*SW + MW]   = row[6][e];
    end
    return r;
  endfunction

  // drive on negedge, drop valid next negedge, sample there (after capture edge)
  task automatic apply(input logic [BW-1:0] m);
    logic [BW-1:0] exp;
    exp = ref_cnu(m);
    @(negedge clk_i);
    msg_i = m;
    valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    chk(valid_o === 1'b1, "R6 valid_o after strobe", 64'(valid_o), 64'd1);
    for (int e = 0; e < DEG; e++) begin
      chk(msg_o[e*SW +: MW] === exp[e*SW +: MW], $sformatf("R3 mag edge %0d", e),
          64'(msg_o[e*SW +: MW]), 64'(exp[e*SW +: MW]));
      chk(msg_o[e*SW + MW] === exp[e*SW + MW], $sformatf("R1/R2 sign edge %0d", e),
          64'(msg_o[e*SW + MW]), 64'(exp[e*SW + MW]));
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [BW-1:0] held;
    logic [BW-1:0] rm;
    repeat (3) @(negedge clk_i);
    chk(valid_o === 1'b0, "R8 reset valid_o", 64'(valid_o), 64'd0);
    chk(msg_o === '0, "R8 reset msg_o", 64'(msg_o), 64'd0);
    rst_ni = 1'b1;

    for (int v = 0; v < NV; v++) apply(pack(TAB[v]));

    // random, every other set drawn from a narrow range to force ties
    for (int k = 0; k < 40; k++) begin
      for (int e = 0; e < DEG; e++) begin
        rm[e*SW +: MW] = (k % 2 == 0) ? MW'($urandom % 4) : MW'($urandom);
        rm[e*SW + MW]  = 1'($urandom);
      end
      apply(rm);
    end

    // R4: duplicated minimum reaches every edge
    apply(pack(TAB[6]));
    for (int e = 0; e < DEG; e++)
      chk(msg_o[e*SW +: MW] === 5'd2, $sformatf("R4 tie edge %0d", e),
          64'(msg_o[e*SW +: MW]), 64'd2);

    // R5: two zero magnitudes with all signs negative give all-zero output
    apply(pack('{0, 6, 0, 2, 3, 4, 6'b111111}));
    chk(msg_o === '0, "R5 zero sign", 64'(msg_o), 64'd0);

    // R6/R7: without valid, output holds and valid_o drops
    held = msg_o;
    msg_i = pack(TAB[0]);
    @(negedge clk_i);
    chk(valid_o === 1'b0, "R6 valid_o low", 64'(valid_o), 64'd0);
    chk(msg_o === held, "R7 hold", 64'(msg_o), 64'(held));
    msg_i = pack(TAB[5]);
    @(negedge clk_i);
    chk(msg_o === held, "R7 hold second", 64'(msg_o), 64'(held));

    // R8: reset mid-run clears outputs
    rst_ni = 1'b0;
    #1;
    chk(valid_o === 1'b0 && msg_o === '0, "R8 async reset", 64'(msg_o), 64'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule